// File: doc/BRIEF.md
# Two-Stage Operand Reservation Station

This block sits between the decode stage and one execution unit of an out-of-order core. Decode offers one instruction at a time: an opcode, one value per source operand, and for each operand a hazard flag with the tag of the in-flight instruction that will produce it. The block watches the shared write-back bus and hands a fully resolved operand set to the execution unit through a plain register stage. The unit accepts that set with `ex_take`.

The station has two stages in series. The hold stage is a single-entry finite-state machine with the states `BS_EMPTY` and `BS_HOLD`. The execute stage is an operand register with the states `EX_EMPTY` and `EX_FULL`. Hazard resolution happens only in the hold stage.

In `BS_EMPTY`, an accepted push whose operands are all resolved goes straight into the execute stage if that stage is free. This is the bypass transition, and the hold stage stays in `BS_EMPTY`. Any other accepted push takes the capture transition `BS_EMPTY -> BS_HOLD`. In `BS_HOLD`, the issue transition `BS_HOLD -> BS_EMPTY` fires once every pending operand has seen its write-back and the execute stage is free. The execute stage takes the fill transition `EX_EMPTY -> EX_FULL` on any load. It takes the drain transition `EX_FULL -> EX_EMPTY` when the unit takes the operands and nothing new loads in the same cycle. While the hold stage is occupied, the station reports busy, and a push aimed at it stalls decode and fetch. Because the hold stage is a register, the advance control never forms a long combinational path.

Top module: `rsv_station`

## Requirements
- R1: After reset, `rs_busy` and `ex_valid` are both 0.
- R2: A push with no hazard flags, accepted while the execute stage is free, sets `ex_valid` on the next clock. On that clock `ex_opc` and `ex_opnd` equal the pushed values, and `rs_busy` stays 0. Operand i occupies `ex_opnd[i*DATA_W +: DATA_W]`, and the same packing applies to `dec_opnd` and `dec_tag`.
- R3: A push with at least one hazard that no same-cycle write-back resolves sets `rs_busy` on the next clock and does not load the execute stage.
- R4: A held operand whose pending tag equals `wb_tag` while `wb_valid` is 1 takes `wb_data` as its value. A write-back with any other tag leaves the operand pending and its value unchanged.
- R5: When the last pending operand of the held instruction resolves and the execute stage is free, the instruction enters the execute stage on that clock and `rs_busy` falls. This holds also when the resolving write-back arrives in that same cycle.
- R6: A push whose hazards are all resolved by the write-back present in the push cycle is treated as hazard-free. It takes the bypass path, and the operand receives `wb_data`.
- R7: `stall` is 1 exactly when `dec_push` is 1 and `rs_busy` is 1. A push made while `rs_busy` is 1 is ignored and does not change the held instruction.
- R8: While `ex_valid` is 1 and `ex_take` is 0, `ex_valid`, `ex_opc` and `ex_opnd` keep their values. A held instruction does not move until the execute stage is empty or is being taken in that cycle.
- R9: A hazard-free push that arrives while the execute stage is full and not being taken is captured in the hold stage, which sets `rs_busy`. It issues once the execute stage frees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_push | input | 1 | Decode offers an instruction to this station |
| dec_opc | input | OPC_W | Opcode of the offered instruction |
| dec_opnd | input | NUM_OPS*DATA_W | Packed operand values |
| dec_hzd | input | NUM_OPS | Per-operand hazard flag |
| dec_tag | input | NUM_OPS*TAG_W | Packed producer tags |
| wb_valid | input | 1 | Write-back bus carries a result |
| wb_tag | input | TAG_W | Tag of the write-back result |
| wb_data | input | DATA_W | Write-back result value |
| ex_take | input | 1 | Execution unit accepts the execute-stage operands |
| rs_busy | output | 1 | Hold stage occupied |
| stall | output | 1 | Stall decode and fetch |
| ex_valid | output | 1 | Execute stage holds operands |
| ex_opc | output | OPC_W | Opcode presented to the unit |
| ex_opnd | output | NUM_OPS*DATA_W | Operands presented to the unit |

## Verification
The write-back that clears a hazard can land in the same cycle as the event that consumes the result. That event is either a push from decode, which decides bypass or capture, or the issue from the hold stage, which forwards the result into the execute stage. The bench provokes both directed cases. It also drives a long stretch with tags drawn from a small set, so that write-backs hit pending operands in every cycle position, often together with `ex_take`. On every clock a behavioural model judges the result: it first applies the snoop and then decides the move, and it compares the busy flag, the execute-stage contents and `stall`.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
    typedef enum logic {BS_EMPTY = 1'b0, BS_HOLD = 1'b1} hold_state_t;
    typedef enum logic {EX_EMPTY = 1'b0, EX_FULL = 1'b1} exec_state_t;
endpackage

// File: rtl/rsv_opnd_slot.sv
module rsv_opnd_slot #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              cap_hzd,
    input  logic [TAG_W-1:0]  cap_tag,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_data,
    output logic              push_ok,
    output logic [DATA_W-1:0] push_val,
    output logic              held_ok,
    output logic [DATA_W-1:0] held_val
);
    logic              pend_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] val_q;
    logic              hit_new;
    logic              hit_old;

    always_comb begin
        hit_new  = wb_valid && (wb_tag == cap_tag);
        hit_old  = wb_valid && (wb_tag == tag_q);
        push_ok  = !cap_hzd || hit_new;
        push_val = cap_hzd ? wb_data : cap_data;
        held_ok  = !pend_q || hit_old;
        held_val = pend_q ? wb_data : val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            tag_q  <= '0;
            val_q  <= '0;
        end else if (cap) begin
            pend_q <= !push_ok;
            tag_q  <= cap_tag;
            val_q  <= push_val;
        end else if (pend_q && hit_old) begin
            pend_q <= 1'b0;
            val_q  <= wb_data;
        end
    end
endmodule

// File: rtl/rsv_exec_reg.sv
module rsv_exec_reg
    import rsv_pkg::*;
#(
    parameter int OPC_W = 6,
    parameter int VEC_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [OPC_W-1:0] ld_opc,
    input  logic [VEC_W-1:0] ld_opnd,
    input  logic             take,
    output logic             free,
    output logic             valid,
    output logic [OPC_W-1:0] opc,
    output logic [VEC_W-1:0] opnd
);
    exec_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EX_EMPTY: if (load) st_d = EX_FULL;
            EX_FULL:  if (take && !load) st_d = EX_EMPTY;
            default:  st_d = EX_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= EX_EMPTY;
            opc  <= '0;
            opnd <= '0;
        end else begin
            st_q <= st_d;
            if (load) begin
                opc  <= ld_opc;
                opnd <= ld_opnd;
            end
        end
    end

    always_comb begin
        valid = (st_q == EX_FULL);
        free  = (st_q == EX_EMPTY) || take;
    end
endmodule

// File: rtl/rsv_station.sv
module rsv_station
    import rsv_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 4,
    parameter int NUM_OPS = 2,
    parameter int OPC_W   = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dec_push,
    input  logic [OPC_W-1:0]          dec_opc,
    input  logic [NUM_OPS*DATA_W-1:0] dec_opnd,
    input  logic [NUM_OPS-1:0]        dec_hzd,
    input  logic [NUM_OPS*TAG_W-1:0]  dec_tag,
    input  logic                      wb_valid,
    input  logic [TAG_W-1:0]          wb_tag,
    input  logic [DATA_W-1:0]         wb_data,
    input  logic                      ex_take,
    output logic                      rs_busy,
    output logic                      stall,
    output logic                      ex_valid,
    output logic [OPC_W-1:0]          ex_opc,
    output logic [NUM_OPS*DATA_W-1:0] ex_opnd
);
    localparam int VEC_W = NUM_OPS * DATA_W;

    hold_state_t st_q, st_d;

    logic [NUM_OPS-1:0] push_ok, held_ok;
    logic [VEC_W-1:0]   push_vals, held_vals, ld_vals;
    logic [OPC_W-1:0]   opc_q, ld_opc;
    logic               accept, bypass, issue, capture, ex_free;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_slot
        rsv_opnd_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap      (capture),
            .cap_hzd  (dec_hzd[i]),
            .cap_tag  (dec_tag[i*TAG_W +: TAG_W]),
            .cap_data (dec_opnd[i*DATA_W +: DATA_W]),
            .wb_valid (wb_valid),
            .wb_tag   (wb_tag),
            .wb_data  (wb_data),
            .push_ok  (push_ok[i]),
            .push_val (push_vals[i*DATA_W +: DATA_W]),
            .held_ok  (held_ok[i]),
            .held_val (held_vals[i*DATA_W +: DATA_W])
        );
    end

    always_comb begin
        accept  = dec_push && (st_q == BS_EMPTY);
        bypass  = accept && (&push_ok) && ex_free;
        capture = accept && !bypass;
        issue   = (st_q == BS_HOLD) && (&held_ok) && ex_free;
        st_d    = st_q;
        unique case (st_q)
            BS_EMPTY: if (capture) st_d = BS_HOLD;
            BS_HOLD:  if (issue)   st_d = BS_EMPTY;
            default:  st_d = BS_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= BS_EMPTY;
            opc_q <= '0;
        end else begin
            st_q <= st_d;
            if (capture) opc_q <= dec_opc;
        end
    end

    always_comb begin
        rs_busy = (st_q == BS_HOLD);
        stall   = dec_push && rs_busy;
        ld_vals = bypass ? push_vals : held_vals;
        ld_opc  = bypass ? dec_opc : opc_q;
    end

    rsv_exec_reg #(.OPC_W(OPC_W), .VEC_W(VEC_W)) u_exec (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (bypass || issue),
        .ld_opc  (ld_opc),
        .ld_opnd (ld_vals),
        .take    (ex_take),
        .free    (ex_free),
        .valid   (ex_valid),
        .opc     (ex_opc),
        .opnd    (ex_opnd)
    );
endmodule

// File: rtl/rsv_station_chk.sv
module rsv_station_chk #(
    parameter int DATA_W  = 32,
    parameter int NUM_OPS = 2,
    parameter int OPC_W   = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      dec_push,
    input logic [NUM_OPS-1:0]        dec_hzd,
    input logic                      wb_valid,
    input logic                      ex_take,
    input logic                      rs_busy,
    input logic                      stall,
    input logic                      ex_valid,
    input logic [OPC_W-1:0]          ex_opc,
    input logic [NUM_OPS*DATA_W-1:0] ex_opnd
);
    // R8
    ex_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid && !ex_take |=> ex_valid && $stable(ex_opc) && $stable(ex_opnd));

    // R3
    hazard_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_push && !rs_busy && (|dec_hzd) && !wb_valid |=> rs_busy);

    // R2
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_push && !rs_busy && (dec_hzd == '0) && (!ex_valid || ex_take)
        |=> ex_valid && !rs_busy);

    // R7
    stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> rs_busy && dec_push);

    // R7
    push_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_busy && dec_push |-> stall);

    // R5
    issue_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rs_busy) |-> ex_valid);
endmodule

bind rsv_station rsv_station_chk #(
    .DATA_W(DATA_W), .NUM_OPS(NUM_OPS), .OPC_W(OPC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dec_push(dec_push), .dec_hzd(dec_hzd),
    .wb_valid(wb_valid), .ex_take(ex_take), .rs_busy(rs_busy), .stall(stall),
    .ex_valid(ex_valid), .ex_opc(ex_opc), .ex_opnd(ex_opnd)
);

// File: tb/rsv_station_test.sv
`timescale 1ns/1ps
module rsv_station_test;
    localparam int DW = 32, TW = 4, NO = 2, OW = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic dec_push = 0;
    logic [OW-1:0] dec_opc = 0;
    logic [NO*DW-1:0] dec_opnd = 0;
    logic [NO-1:0] dec_hzd = 0;
    logic [NO*TW-1:0] dec_tag = 0;
    logic wb_valid = 0;
    logic [TW-1:0] wb_tag = 0;
    logic [DW-1:0] wb_data = 0;
    logic ex_take = 0;
    logic rs_busy, stall, ex_valid;
    logic [OW-1:0] ex_opc;
    logic [NO*DW-1:0] ex_opnd;

    int n_chk = 0, n_bad = 0, cyc = 0;

    rsv_station uut (.*);

    always #10 clk = ~clk;

    // behavioural reference model
    bit m_busy, m_exv;
    bit m_pend [NO];
    int unsigned m_tag [NO];
    logic [DW-1:0] m_val [NO], m_exval [NO];
    logic [OW-1:0] m_opc, m_exopc;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            bit free, all;
            bit ok [NO];
            logic [DW-1:0] v [NO];
            chk(stall === (dec_push && m_busy), "R7 stall", 64'(stall), 64'(dec_push && m_busy));
            free = !m_exv || ex_take;
            if (m_exv && ex_take) m_exv = 0;
            if (!m_busy && dec_push) begin
                all = 1;
                for (int i = 0; i < NO; i++) begin
                    ok[i] = !dec_hzd[i] || (wb_valid && wb_tag == dec_tag[i*TW +: TW]);
                    v[i] = dec_hzd[i] ? wb_data : dec_opnd[i*DW +: DW];
                    all = all && ok[i];
                end
                if (all && free) begin
                    m_exv = 1; m_exopc = dec_opc;
                    for (int i = 0; i < NO; i++) m_exval[i] = v[i];
                end else begin
                    m_busy = 1; m_opc = dec_opc;
                    for (int i = 0; i < NO; i++) begin
                        m_pend[i] = !ok[i]; m_val[i] = v[i];
                        m_tag[i] = dec_tag[i*TW +: TW];
                    end
                end
            end else if (m_busy) begin
                all = 1;
                for (int i = 0; i < NO; i++) begin
                    if (m_pend[i] && wb_valid && wb_tag == m_tag[i]) begin
                        m_pend[i] = 0; m_val[i] = wb_data;
                    end
                    all = all && !m_pend[i];
                end
                if (all && free) begin
                    m_busy = 0; m_exv = 1; m_exopc = m_opc;
                    for (int i = 0; i < NO; i++) m_exval[i] = m_val[i];
                end
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            chk(0, "watchdog", 64'(cyc), 64'd5000);
            finish_run();
        end
        if (rst_n) begin
            chk(rs_busy === m_busy, "R3 rs_busy", 64'(rs_busy), 64'(m_busy));
            chk(ex_valid === m_exv, "R8 ex_valid", 64'(ex_valid), 64'(m_exv));
            if (m_exv) begin
                chk(ex_opc === m_exopc, "R2 ex_opc", 64'(ex_opc), 64'(m_exopc));
                for (int i = 0; i < NO; i++)
                    chk(ex_opnd[i*DW +: DW] === m_exval[i], "R4 ex_opnd",
                        64'(ex_opnd[i*DW +: DW]), 64'(m_exval[i]));
            end
        end
    end

    task automatic idle();
        dec_push = 0; dec_hzd = 0; wb_valid = 0; ex_take = 0;
    endtask

    task automatic push(input logic [OW-1:0] opc, input logic [DW-1:0] a, input logic [DW-1:0] b,
                        input logic [NO-1:0] hz, input logic [TW-1:0] t0, input logic [TW-1:0] t1);
        dec_push = 1; dec_opc = opc; dec_opnd = {b, a}; dec_hzd = hz; dec_tag = {t1, t0};
    endtask

    task automatic wb(input logic [TW-1:0] t, input logic [DW-1:0] d);
        wb_valid = 1; wb_tag = t; wb_data = d;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk(rs_busy === 0 && ex_valid === 0, "R1 reset", 64'({rs_busy, ex_valid}), 64'd0);
        rst_n = 1;
        // R2 bypass
        @(negedge clk); push(6'h11, 32'hA0, 32'hB0, 2'b00, 0, 0);
        @(negedge clk); idle();
        chk(ex_valid && !rs_busy && ex_opnd == {32'hB0, 32'hA0}, "R2 bypass",
            64'(ex_opnd[31:0]), 64'hA0);
        // R3 capture while unit takes old operands
        ex_take = 1; push(6'h12, 32'hA1, 32'h0, 2'b10, 0, 5);
        @(negedge clk); idle();
        chk(rs_busy && !ex_valid, "R3 capture", 64'({rs_busy, ex_valid}), 64'b10);
        // R4 wrong tag ignored; R7 push while busy stalls and is ignored
        wb(3, 32'hDEAD); push(6'h3F, 32'h1, 32'h2, 2'b00, 0, 0);
        #1 chk(stall === 1, "R7 stall", 64'(stall), 64'd1);
        @(negedge clk); idle();
        chk(rs_busy, "R4 mismatch tag keeps pending", 64'(rs_busy), 64'd1);
        // R5 resolving write-back forwards on issue
        wb(5, 32'hC5);
        @(negedge clk); idle();
        chk(!rs_busy && ex_valid && ex_opnd[63:32] == 32'hC5 && ex_opc == 6'h12, "R5 issue",
            64'(ex_opnd[63:32]), 64'hC5);
        // R6 same-cycle resolution at push
        ex_take = 1; push(6'h13, 32'h0, 32'hB3, 2'b01, 7, 0); wb(7, 32'h77);
        @(negedge clk); idle();
        chk(!rs_busy && ex_valid && ex_opnd[31:0] == 32'h77, "R6 bypass on same-cycle wb",
            64'(ex_opnd[31:0]), 64'h77);
        // R9 hazard-free push meets full execute stage; R8 holds
        push(6'h14, 32'hA4, 32'hB4, 2'b00, 0, 0);
        @(negedge clk); idle();
        chk(rs_busy && ex_opc == 6'h13, "R9 captured while full", 64'(ex_opc), 64'h13);
        @(negedge clk);
        chk(ex_opc == 6'h13 && rs_busy, "R8 held until take", 64'(ex_opc), 64'h13);
        ex_take = 1;
        @(negedge clk); idle();
        chk(!rs_busy && ex_valid && ex_opc == 6'h14, "R9 issues after take", 64'(ex_opc), 64'h14);
        // random phase
        for (int k = 0; k < 1500; k++) begin
            @(negedge clk);
            dec_push = ($urandom % 3) != 0;
            dec_opc = OW'($urandom);
            dec_opnd = {$urandom, $urandom};
            dec_hzd = NO'($urandom);
            dec_tag = {TW'($urandom % 4), TW'($urandom % 4)};
            wb_valid = ($urandom % 2) != 0;
            wb_tag = TW'($urandom % 4);
            wb_data = $urandom;
            ex_take = ($urandom % 3) != 0;
        end
        @(negedge clk); idle();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule